// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block translates a 24-bit virtual address into a 32-bit physical address within the same cycle. The upper eleven address bits form the page number. That page number is compared in parallel against every stored entry, and the low 13 bits pass straight through as the page offset. Each entry also carries a process tag, and the entry is used only when that tag equals the current process register. When no valid entry matches, the block raises a miss trap and stops there. It never reads memory itself. Software then loads the missing translation through a one-cycle install port.

Two commands help with a context switch. A valid-clear drops every entry's valid bit in one cycle. A flush wipes every entry and also rewinds the suggested-victim counter. The block keeps the referenced and dirty flags up to date as hits occur. A write that hits a read-only page raises a protection fault. If two valid entries match at once, the lowest index is used and an error flag is set.

Top module: `xlat_tlb`

## Requirements
- R1: For a lookup (`lk_valid`=1) that hits, `lk_hit` is 1 in the same cycle and `lk_paddr` is the matching entry's frame number followed by `lk_vaddr[12:0]` unchanged. Otherwise `lk_paddr` is 0.
- R2: An entry matches only when all three hold: its V flag is set, its page number equals `lk_vaddr[23:13]`, and its process tag equals the current process register. That register is 0 after reset and takes `pid_val` at the edge where `pid_set` is 1.
- R3: A lookup that matches no entry gives `lk_miss_trap`=1, with `lk_hit`, `lk_prot_fault`, `lk_paddr` and `lk_flags` all 0. With `lk_valid`=0, all lookup outputs are 0.
- R4: With `wr_en`=1, entry `wr_idx` takes `wr_vpn`, `wr_pfn`, `wr_pid` and `wr_flags` at the clock edge. A lookup in that same cycle still sees the old contents.
- R5: `clr_valid` clears the V flag of every entry at the edge, so every lookup afterwards misses until entries are installed again.
- R6: `flush` empties every entry and returns `victim_idx` to 0.
- R7: When two or more valid entries match, the lowest-numbered one supplies the outputs and `lk_multi_hit` is 1.
- R8: A lookup with `lk_is_write`=1 whose matching entry has W clear gives `lk_prot_fault`=1, `lk_hit`=0 and `lk_paddr`=0, and it leaves the entry's flags unchanged.
- R9: `lk_flags` reports the matching entry's stored flags as {D,R,W,V} in bits 3..0, taken before this lookup takes effect. A hit sets R at the edge, and a write hit also sets D.
- R10: `victim_idx` is 0 after reset. It advances by one, wrapping after the last entry, on each accepted install.
- R11: When commands coincide, flush takes precedence over valid-clear. Valid-clear takes precedence over an install and over flag updates, and a suppressed install does not advance `victim_idx`. When an install and a flag update target the same entry, the install wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | A lookup is requested this cycle |
| lk_is_write | input | 1 | The lookup is for a store access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| pid_set | input | 1 | Load the current process register |
| pid_val | input | PID_W | New current process value |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | IDX_W | Entry index to install |
| wr_vpn | input | VA_W-OFF_W | Page number to install |
| wr_pfn | input | PA_W-OFF_W | Frame number to install |
| wr_pid | input | PID_W | Process tag to install |
| wr_flags | input | 4 | Flags to install, {D,R,W,V} |
| flush | input | 1 | Empty all entries and rewind the victim counter |
| clr_valid | input | 1 | Clear every V flag |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss_trap | output | 1 | No matching entry; software refill needed |
| lk_prot_fault | output | 1 | Store access to a read-only page |
| lk_multi_hit | output | 1 | More than one entry matched |
| lk_paddr | output | PA_W | Translated physical address |
| lk_flags | output | 4 | Matching entry's stored flags, {D,R,W,V} |
| victim_idx | output | IDX_W | Suggested replacement index |

## Verification
The bench builds the block with 8 entries and a 3-bit process tag, and keeps the 24-bit virtual and 32-bit physical widths. The small entry count lets random installs fill the whole cache and wrap the victim counter many times within a short run. Drawing page numbers and tags from a narrow range produces frequent duplicate matches, tag mismatches and read-only store faults. Directed cycles cover the cases that random stimulus reaches only rarely: a lookup in the same cycle as an install, a valid-clear in the same cycle as an install, and a flush.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

   // Entry flag group; packed order gives bit 3 = dirty ... bit 0 = valid.
   typedef struct packed {
      logic dirty;
      logic refd;
      logic wrok;
      logic valid;
   } tlb_flags_t;

   localparam int FLAG_W = $bits(tlb_flags_t);

   function automatic tlb_flags_t flags_from_bits(input logic [3:0] b);
      tlb_flags_t f;
      f.dirty = b[3];
      f.refd  = b[2];
      f.wrok  = b[1];
      f.valid = b[0];
      return f;
   endfunction

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
   import xlat_tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 11,
   parameter int PFN_W   = 19,
   parameter int PID_W   = 8,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               clr_valid,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PFN_W-1:0]   wr_pfn,
   input  logic [PID_W-1:0]   wr_pid,
   input  tlb_flags_t         wr_flags,
   input  logic               upd_en,
   input  logic               upd_dirty,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [PID_W-1:0]   cur_pid,
   input  logic [IDX_W-1:0]   sel_idx,
   output logic [ENTRIES-1:0] match_vec,
   output logic [PFN_W-1:0]   sel_pfn,
   output tlb_flags_t         sel_flags
);

   logic [VPN_W-1:0] vpn_q [ENTRIES];
   logic [PFN_W-1:0] pfn_q [ENTRIES];
   logic [PID_W-1:0] pid_q [ENTRIES];
   tlb_flags_t       flg_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic inst_here;
      logic upd_here;

      assign inst_here = wr_en  && (wr_idx  == IDX_W'(i));
      assign upd_here  = upd_en && (sel_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_q[i] <= '0;
            pfn_q[i] <= '0;
            pid_q[i] <= '0;
            flg_q[i] <= '0;
         end else if (flush) begin
            vpn_q[i] <= '0;
            pfn_q[i] <= '0;
            pid_q[i] <= '0;
            flg_q[i] <= '0;
         end else if (clr_valid) begin
            flg_q[i].valid <= 1'b0;
         end else if (inst_here) begin
            vpn_q[i] <= wr_vpn;
            pfn_q[i] <= wr_pfn;
            pid_q[i] <= wr_pid;
            flg_q[i] <= wr_flags;
         end else if (upd_here) begin
            flg_q[i].refd <= 1'b1;
            if (upd_dirty) begin
               flg_q[i].dirty <= 1'b1;
            end
         end
      end

      assign match_vec[i] = flg_q[i].valid
                         && (vpn_q[i] == lk_vpn)
                         && (pid_q[i] == cur_pid);
   end

   assign sel_pfn   = pfn_q[sel_idx];
   assign sel_flags = flg_q[sel_idx];

endmodule

// File: rtl/xlat_tlb_pick.sv
module xlat_tlb_pick #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic [ENTRIES-1:0] match_vec,
   output logic               any_o,
   output logic               multi_o,
   output logic [IDX_W-1:0]   idx_o
);

   // Scan from the top down so the lowest set bit is the last one written.
   always_comb begin
      idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            idx_o = IDX_W'(i);
         end
      end
   end

   assign any_o   = |match_vec;
   // Clearing the lowest set bit leaves something only if two or more were set.
   assign multi_o = |(match_vec & (match_vec - ENTRIES'(1)));

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rewind,
   input  logic             adv,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] nxt;

   if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      assign nxt = idx_o + IDX_W'(1);
   end else begin : g_wrap
      assign nxt = (idx_o == LAST) ? '0 : idx_o + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o <= '0;
      end else if (rewind) begin
         idx_o <= '0;
      end else if (adv) begin
         idx_o <= nxt;
      end
   end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_tlb_pkg::*;
#(
   parameter  int VA_W    = 24,
   parameter  int PA_W    = 32,
   parameter  int OFF_W   = 13,
   parameter  int ENTRIES = 64,
   parameter  int PID_W   = 8,
   localparam int VPN_W   = VA_W - OFF_W,
   localparam int PFN_W   = PA_W - OFF_W,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_is_write,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic              pid_set,
   input  logic [PID_W-1:0]  pid_val,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [3:0]        wr_flags,
   input  logic              flush,
   input  logic              clr_valid,
   output logic              lk_hit,
   output logic              lk_miss_trap,
   output logic              lk_prot_fault,
   output logic              lk_multi_hit,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [3:0]        lk_flags,
   output logic [IDX_W-1:0]  victim_idx
);

   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off_va
      $error("xlat_tlb: OFF_W must lie between 1 and VA_W-1");
   end
   if (OFF_W >= PA_W) begin : g_bad_off_pa
      $error("xlat_tlb: OFF_W must be below PA_W");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("xlat_tlb: ENTRIES must be at least 2");
   end
   if (PID_W < 1) begin : g_bad_pid
      $error("xlat_tlb: PID_W must be at least 1");
   end

   logic [PID_W-1:0]   cur_pid_q;
   logic [VPN_W-1:0]   lk_vpn;
   logic [OFF_W-1:0]   lk_off;
   logic [ENTRIES-1:0] match_vec;
   logic               any_m;
   logic               multi_m;
   logic [IDX_W-1:0]   sel_idx;
   logic [PFN_W-1:0]   sel_pfn;
   tlb_flags_t         sel_flags;
   logic               matched;
   logic               fault;
   logic               hit;
   logic               inst_ok;

   assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
   assign lk_off = lk_vaddr[OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_pid_q <= '0;
      end else if (pid_set) begin
         cur_pid_q <= pid_val;
      end
   end

   xlat_tlb_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .PID_W   (PID_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .clr_valid (clr_valid),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_vpn    (wr_vpn),
      .wr_pfn    (wr_pfn),
      .wr_pid    (wr_pid),
      .wr_flags  (flags_from_bits(wr_flags)),
      .upd_en    (hit),
      .upd_dirty (lk_is_write),
      .lk_vpn    (lk_vpn),
      .cur_pid   (cur_pid_q),
      .sel_idx   (sel_idx),
      .match_vec (match_vec),
      .sel_pfn   (sel_pfn),
      .sel_flags (sel_flags)
   );

   xlat_tlb_pick #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_pick (
      .match_vec (match_vec),
      .any_o     (any_m),
      .multi_o   (multi_m),
      .idx_o     (sel_idx)
   );

   assign inst_ok = wr_en && !flush && !clr_valid;

   xlat_tlb_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .rewind (flush),
      .adv    (inst_ok),
      .idx_o  (victim_idx)
   );

   assign matched       = lk_valid && any_m;
   assign fault         = matched && lk_is_write && !sel_flags.wrok;
   assign hit           = matched && !fault;

   assign lk_hit        = hit;
   assign lk_prot_fault = fault;
   assign lk_miss_trap  = lk_valid && !any_m;
   assign lk_multi_hit  = lk_valid && multi_m;
   assign lk_paddr      = hit ? {sel_pfn, lk_off} : '0;
   assign lk_flags      = matched ? sel_flags : '0;

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int VA_W    = 24,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 13,
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_is_write,
   input logic [VA_W-1:0]  lk_vaddr,
   input logic             wr_en,
   input logic             flush,
   input logic             clr_valid,
   input logic             lk_hit,
   input logic             lk_miss_trap,
   input logic             lk_prot_fault,
   input logic             lk_multi_hit,
   input logic [PA_W-1:0]  lk_paddr,
   input logic [3:0]       lk_flags,
   input logic [IDX_W-1:0] victim_idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   assert_offset_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

   assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit || lk_prot_fault) |-> lk_flags[0]);

   assert_miss_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss_trap |-> (!lk_hit && !lk_prot_fault && !lk_multi_hit && lk_paddr == '0));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss_trap && !lk_prot_fault && !lk_multi_hit));

   assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid || flush) |=> (!lk_hit && !lk_prot_fault && !lk_multi_hit));

   assert_flush_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (victim_idx == '0));

   assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_prot_fault |-> (lk_is_write && !lk_flags[1] && !lk_hit && lk_paddr == '0));

   assert_victim_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && !clr_valid) |=>
         (victim_idx == (($past(victim_idx) == LAST) ? '0 : $past(victim_idx) + IDX_W'(1))));

   assert_victim_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && (!wr_en || clr_valid)) |=> $stable(victim_idx));

endmodule

bind xlat_tlb xlat_tlb_chk #(
   .VA_W    (VA_W),
   .PA_W    (PA_W),
   .OFF_W   (OFF_W),
   .ENTRIES (ENTRIES),
   .IDX_W   (IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_is_write   (lk_is_write),
   .lk_vaddr      (lk_vaddr),
   .wr_en         (wr_en),
   .flush         (flush),
   .clr_valid     (clr_valid),
   .lk_hit        (lk_hit),
   .lk_miss_trap  (lk_miss_trap),
   .lk_prot_fault (lk_prot_fault),
   .lk_multi_hit  (lk_multi_hit),
   .lk_paddr      (lk_paddr),
   .lk_flags      (lk_flags),
   .victim_idx    (victim_idx)
);

// File: tb/xlat_tlb_bench.sv
`timescale 1ns/1ps
module xlat_tlb_bench;

   localparam int N    = 8;
   localparam int IW   = 3;
   localparam int PIDW = 3;
   localparam int VW   = 11;
   localparam int FW   = 19;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lk_valid = 1'b0, lk_is_write = 1'b0;
   logic [23:0]     lk_vaddr = '0;
   logic            pid_set = 1'b0;
   logic [PIDW-1:0] pid_val = '0;
   logic            wr_en = 1'b0;
   logic [IW-1:0]   wr_idx = '0;
   logic [VW-1:0]   wr_vpn = '0;
   logic [FW-1:0]   wr_pfn = '0;
   logic [PIDW-1:0] wr_pid = '0;
   logic [3:0]      wr_flags = '0;
   logic            flush = 1'b0, clr_valid = 1'b0;
   logic            lk_hit, lk_miss_trap, lk_prot_fault, lk_multi_hit;
   logic [31:0]     lk_paddr;
   logic [3:0]      lk_flags;
   logic [IW-1:0]   victim_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [VW-1:0]   m_vpn [N];
   logic [FW-1:0]   m_pfn [N];
   logic [PIDW-1:0] m_pid [N];
   logic [3:0]      m_flg [N];
   logic [PIDW-1:0] m_cur = '0;
   int              m_vic = 0;

   always #4 clk = ~clk;

   xlat_tlb #(.ENTRIES(N), .PID_W(PIDW)) u_xlat_tlb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_is_write(lk_is_write),
      .lk_vaddr(lk_vaddr), .pid_set(pid_set), .pid_val(pid_val), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_pid(wr_pid),
      .wr_flags(wr_flags), .flush(flush), .clr_valid(clr_valid), .lk_hit(lk_hit),
      .lk_miss_trap(lk_miss_trap), .lk_prot_fault(lk_prot_fault),
      .lk_multi_hit(lk_multi_hit), .lk_paddr(lk_paddr), .lk_flags(lk_flags),
      .victim_idx(victim_idx)
   );

   function automatic logic [43:0] pack_out(logic h, logic m, logic f, logic mh,
                                            logic [31:0] pa, logic [3:0] fl, logic [IW-1:0] v);
      return {h, m, f, mh, pa, fl, v[2:0], 1'b0};
   endfunction

   task automatic idle_inputs();
      lk_valid = 0; lk_is_write = 0; lk_vaddr = '0; pid_set = 0; pid_val = '0;
      wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_pfn = '0; wr_pid = '0; wr_flags = '0;
      flush = 0; clr_valid = 0;
   endtask

   // Caller sets inputs just after a falling edge; this checks, then advances one cycle.
   task automatic step(input string tag);
      int cnt = 0;
      int first = -1;
      logic e_hit, e_miss, e_flt, e_mh;
      logic [31:0] e_pa;
      logic [3:0]  e_fl;
      logic [43:0] act, exp;
      string t;
      #1;
      for (int i = 0; i < N; i++) begin
         if (m_flg[i][0] && m_vpn[i] == lk_vaddr[23:13] && m_pid[i] == m_cur) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      e_hit = 0; e_miss = 0; e_flt = 0; e_mh = 0; e_pa = '0; e_fl = '0;
      if (lk_valid) begin
         if (cnt == 0) begin
            e_miss = 1;
         end else begin
            e_mh = (cnt > 1);
            e_fl = m_flg[first];
            if (lk_is_write && !m_flg[first][1]) e_flt = 1;
            else begin
               e_hit = 1;
               e_pa  = {m_pfn[first], lk_vaddr[12:0]};
            end
         end
      end
      t = tag;
      if (t == "") begin
         if (!lk_valid) t = "R3";
         else if (e_miss) t = "R3";
         else if (e_mh) t = "R7";
         else if (e_flt) t = "R8";
         else t = "R1";
      end
      act = pack_out(lk_hit, lk_miss_trap, lk_prot_fault, lk_multi_hit, lk_paddr, lk_flags, victim_idx);
      exp = pack_out(e_hit, e_miss, e_flt, e_mh, e_pa, e_fl, IW'(m_vic));
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t {hit,miss,flt,multi,paddr,flags,victim} act=%h exp=%h",
                  t, $time, act, exp);
      end
      @(posedge clk);
      if (flush) begin
         for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_pfn[i] = '0; m_pid[i] = '0; m_flg[i] = '0;
         end
         m_vic = 0;
      end else if (clr_valid) begin
         for (int i = 0; i < N; i++) m_flg[i][0] = 1'b0;
      end else begin
         if (e_hit && !(wr_en && int'(wr_idx) == first)) begin
            m_flg[first][2] = 1'b1;
            if (lk_is_write) m_flg[first][3] = 1'b1;
         end
         if (wr_en) begin
            m_vpn[wr_idx] = wr_vpn; m_pfn[wr_idx] = wr_pfn;
            m_pid[wr_idx] = wr_pid; m_flg[wr_idx] = wr_flags;
            m_vic = (m_vic + 1) % N;
         end
      end
      if (pid_set) m_cur = pid_val;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic look(input logic [VW-1:0] vpn, input logic wr, input string tag);
      lk_valid = 1; lk_is_write = wr;
      lk_vaddr = {vpn, 13'($urandom)};
      step(tag);
   endtask

   task automatic set_inst(input int idx, input logic [VW-1:0] vpn, input logic [FW-1:0] pfn,
                           input logic [PIDW-1:0] pid, input logic [3:0] fl);
      wr_en = 1; wr_idx = IW'(idx); wr_vpn = vpn; wr_pfn = pfn; wr_pid = pid; wr_flags = fl;
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_pfn[i] = '0; m_pid[i] = '0; m_flg[i] = '0;
      end
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // Reset state: idle outputs and victim at 0 (R10), empty cache misses (R3)
      step("R10");
      look(11'd5, 0, "R3");

      // Install with a same-cycle lookup that must still miss (R4)
      set_inst(3, 11'd5, 19'h12345, 3'd0, 4'b0011);
      look(11'd5, 0, "R4");
      look(11'd5, 0, "R1");           // hit, flags 0011
      look(11'd5, 0, "R9");           // R now set: flags 0111
      look(11'd5, 1, "R9");           // write hit
      look(11'd5, 0, "R9");           // D now set: flags 1111

      // Process tag must match the current register (R2)
      pid_set = 1; pid_val = 3'd1;
      step("R2");
      look(11'd5, 0, "R2");
      pid_set = 1; pid_val = 3'd0;
      step("R2");
      look(11'd5, 0, "R2");

      // Duplicate match at lower index, read-only (R7, R8)
      set_inst(1, 11'd5, 19'h00abc, 3'd0, 4'b0001);
      step("R4");
      look(11'd5, 0, "R7");
      look(11'd5, 1, "R8");
      look(11'd5, 0, "R8");           // fault left flags as they were

      // Valid-clear in the same cycle as an install (R11, R5)
      set_inst(6, 11'd7, 19'h7, 3'd0, 4'b0011);
      clr_valid = 1;
      step("R11");
      look(11'd7, 0, "R11");
      look(11'd5, 0, "R5");

      // Victim wrap (R10), then flush rewinds it (R6)
      for (int k = 0; k < N + 2; k++) begin
         set_inst(k % N, 11'(k), 19'(k * 3 + 1), 3'd0, 4'b0011);
         step("R10");
      end
      look(11'd2, 0, "R1");
      flush = 1;
      set_inst(0, 11'd9, 19'h9, 3'd0, 4'b0011);
      step("R6");
      look(11'd9, 0, "R6");
      look(11'd2, 0, "R6");

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom % 1000;
         if (r < 8) flush = 1;
         else if (r < 25) clr_valid = 1;
         if (($urandom % 4) == 0)
            set_inst($urandom % N, (($urandom % 8) == 0) ? 11'($urandom) : 11'($urandom % 4),
                     19'($urandom), 3'($urandom % 2), 4'($urandom));
         if (($urandom % 20) == 0) begin
            pid_set = 1; pid_val = 3'($urandom % 2);
         end
         lk_valid    = (($urandom % 5) != 0);
         lk_is_write = $urandom % 2;
         lk_vaddr    = {(($urandom % 8) == 0) ? 11'($urandom) : 11'($urandom % 4), 13'($urandom)};
         step("");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule